// File: doc/BRIEF.md
# Tagged TLB with Domain Checks

This block is a fully associative translation buffer. It maps virtual page numbers to physical page numbers. Each entry stores a page tag, an address space tag, a global flag, a domain number and three permission bits. On each request, the lookup port compares the virtual page and the current address space tag with every entry at once. One cycle later it returns a hit or a miss, the translated address and a fault status.

Protection has two layers. A register holds a 2-bit access code for every domain, and the domain number of the matching entry picks one of these codes. The code either blocks the access outright (a domain fault), lets the entry's permission bits decide (a permission fault when they deny it), or grants the access without looking at them. The two fault kinds return different status codes, so a handler can tell them apart.

Software-side logic fills entries through a refill port. It removes entries with three invalidation commands: everything, one address space tag, or one virtual page.

Top module: `tlb_tagged_dom`

## Requirements
- R1: After a synchronous reset, all entries are invalid, every domain code is 00, the round-robin pointer is 0 and all result outputs are 0.
- R2: A lookup presented with `lk_valid` in cycle t has its result on the outputs in cycle t+1. `res_valid` is high exactly in the cycles after a lookup request.
- R3: An entry with the global flag set matches a lookup for any `lk_asid`. A non-global entry matches only when its stored tag equals `lk_asid`. If several entries match, the lowest-numbered one is used.
- R4: On a hit without fault, `res_paddr` is the entry's physical page followed by the low `OFF_W` bits of `lk_vaddr`. On a miss, `res_miss`=1, `res_hit`=0, `res_fault`=0, `res_fsr`=00 and `res_paddr`=0. On a fault, `res_paddr`=0.
- R5: Domain code 00 (no access) or 10 (reserved) makes any hit fault with `res_fsr`=10, whatever the permission bits say.
- R6: Domain code 01 (client) checks the permission bits: bit 0 allows reads, bit 1 allows writes, bit 2 forbids fetches. A denied access faults with `res_fsr`=01. `lk_kind` is 00 read, 01 write, 10 fetch, and 11 is treated as a read.
- R7: Domain code 11 (manager) allows every access kind whatever the permission bits.
- R8: The code for domain d sits in bits [2d+1:2d] of the domain register. `dacr_we` loads the whole register, and the change takes effect from the next cycle's lookup.
- R9: Invalidate op 00 clears every entry.
- R10: Invalidate op 01 clears only non-global entries whose tag equals `inv_asid`.
- R11: Invalidate op 10 clears every entry whose page equals `inv_vpn`, global entries included. Op 11 does nothing.
- R12: A refill that duplicates no entry goes into the lowest-numbered invalid entry. When all entries are valid, it goes into the entry the round-robin pointer names, and the pointer then advances by one, wrapping at `ENTRIES`. The pointer moves only on such evictions.
- R13: A refill whose page, global flag and (when non-global) tag equal those of a valid entry overwrites that entry.
- R14: A lookup sees the contents as they were before any refill, invalidation or domain write in the same cycle. When a refill and an invalidation share a cycle, the invalidation is applied first and the refilled entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address space tag |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | VA_W-OFF_W | Refill virtual page |
| fill_ppn | input | PA_W-OFF_W | Refill physical page |
| fill_asid | input | ASID_W | Refill address space tag |
| fill_global | input | 1 | Refill global flag |
| fill_domain | input | $clog2(DOMS) | Refill domain number |
| fill_perm | input | 3 | Refill permissions: read, write, execute-never |
| inv_valid | input | 1 | Invalidation strobe |
| inv_op | input | 2 | 00 all, 01 by tag, 10 by page, 11 none |
| inv_asid | input | ASID_W | Tag for op 01 |
| inv_vpn | input | VA_W-OFF_W | Page for op 10 |
| dacr_we | input | 1 | Domain register write enable |
| dacr_wdata | input | 2*DOMS | New domain register value |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Lookup hit |
| res_miss | output | 1 | Lookup miss |
| res_fault | output | 1 | Hit that is denied |
| res_fsr | output | 2 | Fault status: 00 none, 01 permission, 10 domain |
| res_paddr | output | PA_W | Translated address |

## Verification
The tests drive lookups that hit the same page under matching and non-matching tags, and under global and private mappings. These separate the tag rule from the page compare. Each access kind goes against pages in every domain code, which shows whether a fault comes from the domain layer or from the permission bits, and whether the status code separates the two. Each invalidation kind runs against a mix of global and private entries, then the whole buffer is filled past capacity, so first-free placement can be told apart from round-robin eviction. Same-cycle lookup, refill and invalidate show the order in which updates take effect.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    INV_ALL  = 2'b00,
    INV_ASID = 2'b01,
    INV_PAGE = 2'b10,
    INV_NONE = 2'b11
  } inv_op_e;

  typedef enum logic [1:0] {
    FS_NONE   = 2'b00,
    FS_PERM   = 2'b01,
    FS_DOMAIN = 2'b10,
    FS_RSVD   = 2'b11
  } fault_code_e;

  typedef enum logic [1:0] {
    DOM_NOACC   = 2'b00,
    DOM_CLIENT  = 2'b01,
    DOM_RSVD    = 2'b10,
    DOM_MANAGER = 2'b11
  } dom_code_e;

  localparam int PERM_W  = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_XN = 2;
endpackage

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int N     = 128,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
  parameter int N        = 128,
  parameter int VPN_W    = 20,
  parameter int ASID_W   = 8,
  parameter bit FILL_DUP = 1'b0
) (
  input  logic [N-1:0]             ent_v,
  input  logic [N-1:0]             ent_g,
  input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [N-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]         q_vpn,
  input  logic [ASID_W-1:0]        q_asid,
  input  logic                     q_glob,
  output logic [N-1:0]             match
);
  generate
    if (FILL_DUP) begin : g_dup
      // same page, same global flag, and same tag unless global
      for (genvar i = 0; i < N; i++) begin : g_ent
        assign match[i] = ent_v[i] && (ent_vpn[i] == q_vpn) &&
                          (ent_g[i] == q_glob) &&
                          (q_glob || (ent_asid[i] == q_asid));
      end
    end else begin : g_look
      // global entries ignore the tag
      wire unused_glob = q_glob;
      for (genvar i = 0; i < N; i++) begin : g_ent
        assign match[i] = ent_v[i] && (ent_vpn[i] == q_vpn) &&
                          (ent_g[i] || (ent_asid[i] == q_asid));
      end
    end
  endgenerate
endmodule

// File: rtl/tlb_access_check.sv
module tlb_access_check
  import tlb_pkg::*;
#(
  parameter int DOMS  = 16,
  parameter int DOM_W = $clog2(DOMS)
) (
  input  logic [2*DOMS-1:0] dacr,
  input  logic [DOM_W-1:0]  dom,
  input  logic [PERM_W-1:0] perm,
  input  logic [1:0]        kind,
  output logic              fault,
  output logic [1:0]        fsr
);
  logic [1:0] code;
  logic       denied;

  always_comb begin
    code = dacr[{dom, 1'b0} +: 2];
    case (acc_kind_e'(kind))
      ACC_WRITE: denied = !perm[PERM_WR];
      ACC_FETCH: denied = perm[PERM_XN];
      default:   denied = !perm[PERM_RD];
    endcase
    case (dom_code_e'(code))
      DOM_CLIENT: begin
        fault = denied;
        fsr   = denied ? FS_PERM : FS_NONE;
      end
      DOM_MANAGER: begin
        fault = 1'b0;
        fsr   = FS_NONE;
      end
      default: begin
        fault = 1'b1;
        fsr   = FS_DOMAIN;
      end
    endcase
  end
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
  parameter int N     = 128,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     dup,
  input  logic [IDX_W-1:0] rr,
  output logic [IDX_W-1:0] slot,
  output logic             evict
);
  logic             has_dup, has_free;
  logic [IDX_W-1:0] dup_idx, free_idx;

  tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_dup (
    .vec(dup), .found(has_dup), .idx(dup_idx)
  );
  tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_free (
    .vec(~valid), .found(has_free), .idx(free_idx)
  );

  always_comb begin
    evict = !has_dup && !has_free;
    if (has_dup)       slot = dup_idx;
    else if (has_free) slot = free_idx;
    else               slot = rr;
  end
endmodule

// File: rtl/tlb_tagged_dom.sv
module tlb_tagged_dom
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8,
  parameter int DOMS    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lk_valid,
  input  logic [VA_W-1:0]             lk_vaddr,
  input  logic [ASID_W-1:0]           lk_asid,
  input  logic [1:0]                  lk_kind,
  input  logic                        fill_valid,
  input  logic [VA_W-OFF_W-1:0]       fill_vpn,
  input  logic [PA_W-OFF_W-1:0]       fill_ppn,
  input  logic [ASID_W-1:0]           fill_asid,
  input  logic                        fill_global,
  input  logic [$clog2(DOMS)-1:0]     fill_domain,
  input  logic [2:0]                  fill_perm,
  input  logic                        inv_valid,
  input  logic [1:0]                  inv_op,
  input  logic [ASID_W-1:0]           inv_asid,
  input  logic [VA_W-OFF_W-1:0]       inv_vpn,
  input  logic                        dacr_we,
  input  logic [2*DOMS-1:0]           dacr_wdata,
  output logic                        res_valid,
  output logic                        res_hit,
  output logic                        res_miss,
  output logic                        res_fault,
  output logic [1:0]                  res_fsr,
  output logic [PA_W-1:0]             res_paddr
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int DOM_W = $clog2(DOMS);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  // entry storage: valid bits reset, payload written one index per cycle
  logic [ENTRIES-1:0]             v_q;
  logic [ENTRIES-1:0]             g_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][DOM_W-1:0]  dom_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

  logic [2*DOMS-1:0] dacr_q;
  logic [IDX_W-1:0]  rr_q;

  // ---------------- lookup ----------------
  logic [ENTRIES-1:0] look_match;
  logic               look_hit;
  logic [IDX_W-1:0]   look_idx;
  logic               chk_fault;
  logic [1:0]         chk_fsr;

  tlb_tag_match #(
    .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .FILL_DUP(1'b0)
  ) u_look_match (
    .ent_v(v_q), .ent_g(g_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .q_vpn(lk_vaddr[VA_W-1:OFF_W]), .q_asid(lk_asid), .q_glob(1'b0),
    .match(look_match)
  );

  tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_look_enc (
    .vec(look_match), .found(look_hit), .idx(look_idx)
  );

  tlb_access_check #(.DOMS(DOMS), .DOM_W(DOM_W)) u_access (
    .dacr(dacr_q), .dom(dom_q[look_idx]), .perm(perm_q[look_idx]),
    .kind(lk_kind), .fault(chk_fault), .fsr(chk_fsr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_fault <= 1'b0;
      res_fsr   <= FS_NONE;
      res_paddr <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && look_hit;
      res_miss  <= lk_valid && !look_hit;
      res_fault <= lk_valid && look_hit && chk_fault;
      res_fsr   <= (lk_valid && look_hit) ? chk_fsr : FS_NONE;
      if (lk_valid && look_hit && !chk_fault)
        res_paddr <= {ppn_q[look_idx], lk_vaddr[OFF_W-1:0]};
      else
        res_paddr <= '0;
    end
  end

  // ---------------- refill placement ----------------
  logic [ENTRIES-1:0] dup_match;
  logic [IDX_W-1:0]   fill_slot;
  logic               fill_evict;

  tlb_tag_match #(
    .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .FILL_DUP(1'b1)
  ) u_dup_match (
    .ent_v(v_q), .ent_g(g_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .q_vpn(fill_vpn), .q_asid(fill_asid), .q_glob(fill_global),
    .match(dup_match)
  );

  tlb_slot_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .valid(v_q), .dup(dup_match), .rr(rr_q),
    .slot(fill_slot), .evict(fill_evict)
  );

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (fill_valid && fill_evict) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  // ---------------- invalidation ----------------
  logic [ENTRIES-1:0] kill;
  logic [ENTRIES-1:0] v_nxt;

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_kill
      always_comb begin
        kill[i] = 1'b0;
        if (inv_valid) begin
          case (inv_op_e'(inv_op))
            INV_ALL:  kill[i] = 1'b1;
            INV_ASID: kill[i] = !g_q[i] && (asid_q[i] == inv_asid);
            INV_PAGE: kill[i] = (vpn_q[i] == inv_vpn);
            default:  kill[i] = 1'b0;
          endcase
        end
      end
    end
  endgenerate

  always_comb begin
    v_nxt = v_q & ~kill;
    if (fill_valid) v_nxt[fill_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= v_nxt;
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      g_q[fill_slot]    <= fill_global;
      vpn_q[fill_slot]  <= fill_vpn;
      asid_q[fill_slot] <= fill_asid;
      ppn_q[fill_slot]  <= fill_ppn;
      dom_q[fill_slot]  <= fill_domain;
      perm_q[fill_slot] <= fill_perm;
    end
  end

  // ---------------- domain access register ----------------
  always_ff @(posedge clk) begin
    if (rst)          dacr_q <= '0;
    else if (dacr_we) dacr_q <= dacr_wdata;
  end
endmodule

// File: rtl/tlb_tagged_dom_chk.sv
module tlb_tagged_dom_chk #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  lk_valid,
  input logic [VA_W-1:0]       lk_vaddr,
  input logic                  fill_valid,
  input logic                  inv_valid,
  input logic [1:0]            inv_op,
  input logic [VA_W-OFF_W-1:0] inv_vpn,
  input logic                  res_valid,
  input logic                  res_hit,
  input logic                  res_miss,
  input logic                  res_fault,
  input logic [1:0]            res_fsr,
  input logic [PA_W-1:0]       res_paddr
);
  // R2
  result_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!res_valid && !res_hit && !res_miss && !res_fault));

  // R4
  miss_is_clean_chk: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (!res_hit && !res_fault && res_fsr == 2'b00 && res_paddr == '0));

  // R5
  fault_has_status_chk: assert property (@(posedge clk) disable iff (rst)
    res_fault |-> (res_hit && (res_fsr == 2'b01 || res_fsr == 2'b10) && res_paddr == '0));

  // R9
  flush_all_misses_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $past(inv_valid && inv_op == 2'b00 && !fill_valid)) |=> res_miss);

  // R11
  page_inval_misses_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $past(inv_valid) && $past(inv_op) == 2'b10 && !$past(fill_valid) &&
     $past(inv_vpn) == lk_vaddr[VA_W-1:OFF_W]) |=> res_miss);
endmodule

bind tlb_tagged_dom tlb_tagged_dom_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .fill_valid(fill_valid), .inv_valid(inv_valid), .inv_op(inv_op),
  .inv_vpn(inv_vpn), .res_valid(res_valid), .res_hit(res_hit),
  .res_miss(res_miss), .res_fault(res_fault), .res_fsr(res_fsr),
  .res_paddr(res_paddr)
);

// File: tb/tlb_tagged_dom_tb.sv
module tlb_tagged_dom_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_kind = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic [7:0]  fill_asid = '0;
  logic        fill_global = 1'b0;
  logic [3:0]  fill_domain = '0;
  logic [2:0]  fill_perm = '0;
  logic        inv_valid = 1'b0;
  logic [1:0]  inv_op = '0;
  logic [7:0]  inv_asid = '0;
  logic [19:0] inv_vpn = '0;
  logic        dacr_we = 1'b0;
  logic [31:0] dacr_wdata = '0;
  logic        res_valid, res_hit, res_miss, res_fault;
  logic [1:0]  res_fsr;
  logic [31:0] res_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_tagged_dom u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .lk_kind(lk_kind), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_asid(fill_asid),
    .fill_global(fill_global), .fill_domain(fill_domain), .fill_perm(fill_perm),
    .inv_valid(inv_valid), .inv_op(inv_op), .inv_asid(inv_asid), .inv_vpn(inv_vpn),
    .dacr_we(dacr_we), .dacr_wdata(dacr_wdata), .res_valid(res_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
    .res_fsr(res_fsr), .res_paddr(res_paddr)
  );

  // ---------------- behavioural reference ----------------
  logic        m_v    [N];
  logic        m_g    [N];
  logic [19:0] m_vpn  [N];
  logic [7:0]  m_asid [N];
  logic [19:0] m_ppn  [N];
  logic [3:0]  m_dom  [N];
  logic [2:0]  m_perm [N];
  logic [31:0] m_dacr;
  int          m_rr;
  logic        e_valid = 0, e_hit = 0, e_miss = 0, e_fault = 0;
  logic [1:0]  e_fsr = 0;
  logic [31:0] e_paddr = 0;

  always @(posedge clk) begin
    int h;
    int s;
    logic [1:0] code;
    logic denied;
    if (rst) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      m_rr = 0; m_dacr = '0;
      e_valid = 0; e_hit = 0; e_miss = 0; e_fault = 0; e_fsr = 0; e_paddr = 0;
    end else begin
      e_valid = lk_valid; e_hit = 0; e_miss = 0; e_fault = 0; e_fsr = 0; e_paddr = 0;
      if (lk_valid) begin
        h = -1;
        for (int i = 0; i < N; i++)
          if (h < 0 && m_v[i] && m_vpn[i] == lk_vaddr[31:12] && (m_g[i] || m_asid[i] == lk_asid))
            h = i;
        if (h < 0) e_miss = 1;
        else begin
          e_hit = 1;
          code = m_dacr[2*m_dom[h] +: 2];
          if (lk_kind == 2'b01)      denied = !m_perm[h][1];
          else if (lk_kind == 2'b10) denied = m_perm[h][2];
          else                       denied = !m_perm[h][0];
          if (code == 2'b01) begin
            if (denied) begin e_fault = 1; e_fsr = 2'b01; end
          end else if (code != 2'b11) begin
            e_fault = 1; e_fsr = 2'b10;
          end
          if (!e_fault) e_paddr = {m_ppn[h], lk_vaddr[11:0]};
        end
      end
      s = -1;
      if (fill_valid) begin
        for (int i = 0; i < N; i++)
          if (s < 0 && m_v[i] && m_vpn[i] == fill_vpn && m_g[i] == fill_global &&
              (fill_global || m_asid[i] == fill_asid)) s = i;
        for (int i = 0; i < N; i++)
          if (s < 0 && !m_v[i]) s = i;
        if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % N; end
      end
      if (dacr_we) m_dacr = dacr_wdata;
      if (inv_valid)
        for (int i = 0; i < N; i++) begin
          if (inv_op == 2'b00) m_v[i] = 1'b0;
          else if (inv_op == 2'b01 && !m_g[i] && m_asid[i] == inv_asid) m_v[i] = 1'b0;
          else if (inv_op == 2'b10 && m_vpn[i] == inv_vpn) m_v[i] = 1'b0;
        end
      if (fill_valid) begin
        m_v[s] = 1'b1; m_g[s] = fill_global; m_vpn[s] = fill_vpn; m_asid[s] = fill_asid;
        m_ppn[s] = fill_ppn; m_dom[s] = fill_domain; m_perm[s] = fill_perm;
      end
    end
  end

  // ---------------- comparison every clock ----------------
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    armed = 0;
  bit    done = 0;
  string cur_req = "R1";

  always @(negedge clk) begin
    if (armed && !done) begin
      n_cmp++;
      if (res_valid !== e_valid || res_hit !== e_hit || res_miss !== e_miss ||
          res_fault !== e_fault || res_fsr !== e_fsr || res_paddr !== e_paddr) begin
        n_bad++;
        $display("FAIL %s t=%0t actual v%b h%b m%b f%b s%b pa=%h expected v%b h%b m%b f%b s%b pa=%h",
                 cur_req, $time, res_valid, res_hit, res_miss, res_fault, res_fsr, res_paddr,
                 e_valid, e_hit, e_miss, e_fault, e_fsr, e_paddr);
      end
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic tick();
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; inv_valid = 0; dacr_we = 0;
  endtask

  task automatic put_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [7:0] asid,
                          input logic g, input logic [3:0] dom, input logic [2:0] perm);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_asid = asid;
    fill_global = g; fill_domain = dom; fill_perm = perm;
  endtask

  task automatic put_look(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind);
    lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_kind = kind;
  endtask

  task automatic put_inv(input logic [1:0] op, input logic [7:0] asid, input logic [19:0] vpn);
    inv_valid = 1; inv_op = op; inv_asid = asid; inv_vpn = vpn;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [7:0] asid,
                      input logic g, input logic [3:0] dom, input logic [2:0] perm);
    put_fill(vpn, ppn, asid, g, dom, perm); tick();
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind);
    put_look(va, asid, kind); tick();
  endtask

  task automatic set_dacr(input logic [31:0] val);
    dacr_we = 1; dacr_wdata = val; tick();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
      done = 1;
      finish_run();
    end
  end

  initial begin
    logic [31:0] dv;
    @(posedge clk); #1; armed = 1;
    // R1: reset state and empty buffer
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    look(32'h0001_0123, 8'd5, 2'b00);
    look(32'h0002_0000, 8'd0, 2'b10);
    tick();

    // R8: domain 0 client, 1 no access, 2 manager, 3 reserved, rest client
    cur_req = "R8";
    dv = '0;
    for (int d = 0; d < 16; d++) dv[2*d +: 2] = 2'b01;
    dv[3:2] = 2'b00; dv[5:4] = 2'b11; dv[7:6] = 2'b10;
    set_dacr(dv);

    fill(20'h00010, 20'h00A10, 8'd5, 1'b0, 4'd0, 3'b011);
    fill(20'h00020, 20'h00A20, 8'd5, 1'b1, 4'd0, 3'b001);
    fill(20'h00030, 20'h00A30, 8'd5, 1'b0, 4'd0, 3'b101);
    fill(20'h00040, 20'h00A40, 8'd5, 1'b0, 4'd1, 3'b011);
    fill(20'h00050, 20'h00A50, 8'd5, 1'b0, 4'd2, 3'b100);
    fill(20'h00060, 20'h00A60, 8'd5, 1'b0, 4'd3, 3'b011);
    fill(20'h00070, 20'h00A70, 8'd7, 1'b0, 4'd0, 3'b001);
    fill(20'h00080, 20'h00A80, 8'd5, 1'b0, 4'd0, 3'b000);
    fill(20'h00090, 20'h00A90, 8'd5, 1'b1, 4'd4, 3'b011);

    // R2 / R3: tag rule, global pages, gaps between requests
    cur_req = "R3";
    look(32'h0001_0abc, 8'd5, 2'b00);
    tick();
    look(32'h0001_0abc, 8'd6, 2'b00);
    look(32'h0002_0004, 8'd9, 2'b00);
    look(32'h0007_0ff0, 8'd7, 2'b00);
    look(32'h0007_0ff0, 8'd5, 2'b00);
    cur_req = "R2";
    tick(); tick();

    // R4: address composition with different offsets
    cur_req = "R4";
    look(32'h0001_0000, 8'd5, 2'b01);
    look(32'h0001_0fff, 8'd5, 2'b00);
    look(32'h00FF_F123, 8'd5, 2'b00);

    // R6: permission bits under client domain
    cur_req = "R6";
    look(32'h0002_0010, 8'd1, 2'b01);
    look(32'h0002_0010, 8'd1, 2'b10);
    look(32'h0003_0020, 8'd5, 2'b10);
    look(32'h0003_0020, 8'd5, 2'b00);
    look(32'h0008_0000, 8'd5, 2'b00);
    look(32'h0008_0000, 8'd5, 2'b11);
    look(32'h0001_0040, 8'd5, 2'b10);

    // R5: no access and reserved domains
    cur_req = "R5";
    look(32'h0004_0000, 8'd5, 2'b00);
    look(32'h0004_0000, 8'd5, 2'b10);
    look(32'h0006_0000, 8'd5, 2'b00);

    // R7: manager domain ignores the permission bits
    cur_req = "R7";
    look(32'h0005_0001, 8'd5, 2'b00);
    look(32'h0005_0002, 8'd5, 2'b01);
    look(32'h0005_0003, 8'd5, 2'b10);

    // R8: retarget domain 1 to manager, domain 0 to no access
    cur_req = "R8";
    dv[3:2] = 2'b11; dv[1:0] = 2'b00;
    set_dacr(dv);
    look(32'h0004_0000, 8'd5, 2'b01);
    look(32'h0001_0000, 8'd5, 2'b00);
    dv[1:0] = 2'b01;
    set_dacr(dv);

    // R13: duplicate refill overwrites, other tag is a new entry
    cur_req = "R13";
    fill(20'h00010, 20'h00B10, 8'd5, 1'b0, 4'd0, 3'b001);
    look(32'h0001_0004, 8'd5, 2'b00);
    look(32'h0001_0004, 8'd5, 2'b01);
    fill(20'h00010, 20'h00C10, 8'd6, 1'b0, 4'd0, 3'b011);
    look(32'h0001_0008, 8'd6, 2'b01);
    look(32'h0001_0008, 8'd5, 2'b00);
    fill(20'h00020, 20'h00B20, 8'd3, 1'b1, 4'd2, 3'b000);
    look(32'h0002_0000, 8'd8, 2'b01);

    // R11: page invalidate removes global entries too; op 11 is a no-op
    cur_req = "R11";
    put_inv(2'b11, 8'd5, 20'h00030); tick();
    look(32'h0003_0000, 8'd5, 2'b00);
    put_inv(2'b10, 8'd0, 20'h00020); tick();
    look(32'h0002_0000, 8'd5, 2'b00);
    look(32'h0002_0000, 8'd0, 2'b00);
    put_inv(2'b10, 8'd0, 20'h00010); tick();
    look(32'h0001_0000, 8'd5, 2'b00);
    look(32'h0001_0000, 8'd6, 2'b00);

    // R10: tag invalidate spares globals and other tags
    cur_req = "R10";
    fill(20'h00010, 20'h00D10, 8'd6, 1'b0, 4'd0, 3'b011);
    put_inv(2'b01, 8'd5, 20'h0); tick();
    look(32'h0003_0000, 8'd5, 2'b00);
    look(32'h0005_0000, 8'd5, 2'b00);
    look(32'h0009_0000, 8'd5, 2'b00);
    look(32'h0001_0000, 8'd6, 2'b00);
    look(32'h0007_0000, 8'd7, 2'b00);

    // R9: flush everything
    cur_req = "R9";
    put_inv(2'b00, 8'd0, 20'h0); tick();
    look(32'h0009_0000, 8'd1, 2'b00);
    look(32'h0007_0000, 8'd7, 2'b00);
    look(32'h0001_0000, 8'd6, 2'b00);

    // R12: fill to capacity, then round-robin eviction and first-free reuse
    cur_req = "R12";
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 20'h10000 + 20'(i), 8'd1, 1'b0, 4'd0, 3'b011);
    look(32'h0010_0000, 8'd1, 2'b00);
    look(32'h0017_F000, 8'd1, 2'b00);
    for (int j = 0; j < 3; j++) fill(20'h00200 + 20'(j), 20'h20000 + 20'(j), 8'd1, 1'b0, 4'd0, 3'b011);
    look(32'h0010_0000, 8'd1, 2'b00);
    look(32'h0010_2000, 8'd1, 2'b00);
    look(32'h0010_3000, 8'd1, 2'b00);
    look(32'h0020_2000, 8'd1, 2'b00);
    put_inv(2'b10, 8'd0, 20'h00150); tick();
    fill(20'h00300, 20'h30000, 8'd1, 1'b0, 4'd0, 3'b011);
    look(32'h0030_0000, 8'd1, 2'b00);
    look(32'h0010_3000, 8'd1, 2'b00);
    fill(20'h00301, 20'h30001, 8'd1, 1'b0, 4'd0, 3'b011);
    look(32'h0010_3000, 8'd1, 2'b00);
    look(32'h0010_4000, 8'd1, 2'b00);
    look(32'h0030_1000, 8'd1, 2'b00);

    // R14: same-cycle ordering
    cur_req = "R14";
    put_inv(2'b00, 8'd0, 20'h0); tick();
    put_fill(20'h00400, 20'h40000, 8'd2, 1'b0, 4'd0, 3'b011);
    put_look(32'h0040_0000, 8'd2, 2'b00); tick();
    look(32'h0040_0000, 8'd2, 2'b00);
    put_inv(2'b10, 8'd0, 20'h00400);
    put_look(32'h0040_0010, 8'd2, 2'b00); tick();
    look(32'h0040_0010, 8'd2, 2'b00);
    put_inv(2'b00, 8'd0, 20'h0);
    put_fill(20'h00401, 20'h40001, 8'd2, 1'b0, 4'd0, 3'b011); tick();
    look(32'h0040_1000, 8'd2, 2'b00);
    dv[1:0] = 2'b00;
    dacr_we = 1; dacr_wdata = dv;
    put_look(32'h0040_1000, 8'd2, 2'b00); tick();
    look(32'h0040_1000, 8'd2, 2'b00);
    tick(); tick();

    done = 1;
    finish_run();
  end
endmodule